// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the 64-bit control registers of a processor's privileged state. Each register is reached by a 6-bit index through one request port, and a request is either a read or a write. A read returns data in the same cycle. A write takes effect at the next rising clock edge.

Each register follows its own write rule:
- a full store, or a store through a fixed bit mask;
- a store that clears the register whatever the data;
- a store that may happen only once;
- no store at all (read-only). Some registers accept writes but cannot be read (write-only).

A bad access raises an error flag in the same cycle as the request. Such an access changes nothing and reads as zero. Bad accesses are:
- a forbidden direction;
- an unassigned index;
- a repeated one-time write.

A 32-bit free-running counter supplies the low half of the cycle-count register. The processor mode, the interrupt priority level and two cache-flush strobes are driven to the rest of the core. An exception-summary input lets hardware set sticky bits, which software then clears by writing.

Top module: `priv_ctl_regfile`

## Requirements
- R1: After reset every register reads zero, except three:
  - index 25 (hardware control) reads 0x6;
  - index 24 (ROM base) reads the RESET_BASE parameter;
  - index 16 (scratch 16) reads `cpu_id` zero-extended.
- R2: Scratch registers 0–23, index 24, index 25 and index 44 (hardware-interrupt clear) store all 64 bits of a write.
- R3: Writes are ANDed with a fixed mask:

  | Index | Register | Mask |
  |---|---|---|
  | 27, 28 | AST request / enable | 0xF |
  | 29 | interrupt level | 0x1F |
  | 30, 31, 32 | mode registers | 0x18 |
  | 33 | software interrupt | 0x7FFF0 |
  | 34 | fetch control | 0xFF_FFFF_0300 |
  | 35 | page-table base | 0xFFFFFFFFC0000000 |
  | 36, 37 | cache / miss mode | 0x3F |

- R4: A write to index 26 (fault PC) stores the data with bit 1 forced to 0.
- R5: Index 38 (exception summary) ORs in `exc_sum_set` every cycle.
  - Any write to index 38 or index 39 clears that register regardless of data.
  - Bits set in the same cycle as the clearing write survive it.
- R6: Reading index 40 returns stored bits 63:32 joined with the low 32 bits of a cycle counter. The counter is 0 in the first cycle after reset and rises by one per clock. A write to index 40 stores all 64 bits.
- R7: The first write to index 41 (cycle-count control) is accepted and sets it to 1. Every later write to index 41 raises `acc_err`.
- R8: Direction errors raise `acc_err`:
  - writing index 42 or 43 (read-only);
  - reading index 32, 41, 44, 45 or 46 (write-only).

  An access with an error changes no state, and `rd_data` reads 0 during it.
- R9: Any access to an index from 47 to 63 raises `acc_err`.
- R10: An accepted write to index 31 pulses `mode_chg` for one cycle after the write edge. It also sets `mode_user` to 1 if data bit 3 or bit 4 is set, and to 0 otherwise. Reset gives `mode_user` = 0.
- R11: `irq_level` always equals bits 4:0 of index 29.
- R12: An accepted write to index 45 pulses `dflush_stb`, and one to index 46 pulses `iflush_stb`, for the one cycle after the write edge.
- R13: `rd_data` is 0 whenever no valid error-free read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_id | input | CPU_ID_W | Identifier loaded into scratch 16 at reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 6 | Register index |
| req_wdata | input | 64 | Write data |
| exc_sum_set | input | 64 | Sticky bits ORed into the exception summary |
| rd_data | output | 64 | Combinational read data |
| acc_err | output | 1 | Combinational access error |
| irq_level | output | 5 | Current interrupt priority level |
| mode_user | output | 1 | 1 = user mode, 0 = kernel mode |
| mode_chg | output | 1 | One-cycle pulse after a data-mode write |
| dflush_stb | output | 1 | Data-cache flush strobe |
| iflush_stb | output | 1 | Instruction-cache flush strobe |

## Verification
The masked registers are written with all ones and then with an alternating 0xA5 pattern. The all-ones write shows each mask whole, and the alternating pattern catches a mask with the right population in the wrong place.

The full-store registers receive distinct patterns at both the upper and lower words, which separates a full store from a masked one. Reads of the cycle-count register at spaced intervals separate the live low half from the stored upper half.

Error paths are driven in both directions on every forbidden class, each followed by a read-back to confirm nothing moved. The data-mode register is written with bit 3 only, bit 4 only, and neither, to tell a two-bit OR from a single-bit decode.

// File: rtl/ctl_regfile_pkg.sv
package ctl_regfile_pkg;

    localparam int XLEN      = 64;
    localparam int IDX_W     = 6;
    localparam int NUM_SLOTS = 47;
    localparam int CNT_W     = 32;

    localparam logic [IDX_W-1:0] IX_SCR16      = 6'd16;
    localparam logic [IDX_W-1:0] IX_ROM_BASE   = 6'd24;
    localparam logic [IDX_W-1:0] IX_HW_CTRL    = 6'd25;
    localparam logic [IDX_W-1:0] IX_FAULT_PC   = 6'd26;
    localparam logic [IDX_W-1:0] IX_AST_REQ    = 6'd27;
    localparam logic [IDX_W-1:0] IX_AST_EN     = 6'd28;
    localparam logic [IDX_W-1:0] IX_IRQ_LVL    = 6'd29;
    localparam logic [IDX_W-1:0] IX_FETCH_MODE = 6'd30;
    localparam logic [IDX_W-1:0] IX_DATA_MODE  = 6'd31;
    localparam logic [IDX_W-1:0] IX_ALT_MODE   = 6'd32;
    localparam logic [IDX_W-1:0] IX_SOFT_IRQ   = 6'd33;
    localparam logic [IDX_W-1:0] IX_FETCH_CSR  = 6'd34;
    localparam logic [IDX_W-1:0] IX_PT_BASE    = 6'd35;
    localparam logic [IDX_W-1:0] IX_DC_MODE    = 6'd36;
    localparam logic [IDX_W-1:0] IX_MISS_MODE  = 6'd37;
    localparam logic [IDX_W-1:0] IX_EXC_SUM    = 6'd38;
    localparam logic [IDX_W-1:0] IX_EXC_MASK   = 6'd39;
    localparam logic [IDX_W-1:0] IX_CYC_CNT    = 6'd40;
    localparam logic [IDX_W-1:0] IX_CYC_CTL    = 6'd41;
    localparam logic [IDX_W-1:0] IX_IRQ_ID     = 6'd42;
    localparam logic [IDX_W-1:0] IX_MM_STAT    = 6'd43;
    localparam logic [IDX_W-1:0] IX_HWIRQ_CLR  = 6'd44;
    localparam logic [IDX_W-1:0] IX_DFLUSH     = 6'd45;
    localparam logic [IDX_W-1:0] IX_IFLUSH     = 6'd46;

    localparam logic [XLEN-1:0] HW_CTRL_INIT = 64'h6;

    typedef enum logic [1:0] {
        WK_MASKED = 2'd0,
        WK_CLEAR  = 2'd1,
        WK_ONCE   = 2'd2
    } wr_kind_e;

    typedef struct packed {
        logic            known;
        logic            rd_ok;
        logic            wr_ok;
        wr_kind_e        kind;
        logic [XLEN-1:0] mask;
    } policy_t;

    typedef struct packed {
        logic             valid;
        logic             write;
        logic [IDX_W-1:0] idx;
        logic [XLEN-1:0]  data;
    } req_t;

    function automatic policy_t policy_of(input logic [IDX_W-1:0] idx);
        policy_t p;
        p.known = 1'b1;
        p.rd_ok = 1'b1;
        p.wr_ok = 1'b1;
        p.kind  = WK_MASKED;
        p.mask  = '1;
        if (idx >= IDX_W'(NUM_SLOTS)) begin
            p.known = 1'b0;
            p.rd_ok = 1'b0;
            p.wr_ok = 1'b0;
        end else begin
            case (idx)
                IX_FAULT_PC:                 p.mask = ~64'h2;
                IX_AST_REQ, IX_AST_EN:       p.mask = 64'hF;
                IX_IRQ_LVL:                  p.mask = 64'h1F;
                IX_FETCH_MODE, IX_DATA_MODE: p.mask = 64'h18;
                IX_ALT_MODE: begin
                    p.mask  = 64'h18;
                    p.rd_ok = 1'b0;
                end
                IX_SOFT_IRQ:                 p.mask = 64'h7FFF0;
                IX_FETCH_CSR:                p.mask = 64'hFF_FFFF_0300;
                IX_PT_BASE:                  p.mask = 64'hFFFF_FFFF_C000_0000;
                IX_DC_MODE, IX_MISS_MODE:    p.mask = 64'h3F;
                IX_EXC_SUM, IX_EXC_MASK:     p.kind = WK_CLEAR;
                IX_CYC_CTL: begin
                    p.kind  = WK_ONCE;
                    p.rd_ok = 1'b0;
                end
                IX_IRQ_ID, IX_MM_STAT:       p.wr_ok = 1'b0;
                IX_HWIRQ_CLR, IX_DFLUSH, IX_IFLUSH: p.rd_ok = 1'b0;
                default: ;
            endcase
        end
        return p;
    endfunction

    function automatic logic [XLEN-1:0] apply_write(input wr_kind_e kind,
                                                    input logic [XLEN-1:0] mask,
                                                    input logic [XLEN-1:0] data);
        case (kind)
            WK_CLEAR: return '0;
            WK_ONCE:  return 64'd1;
            default:  return data & mask;
        endcase
    endfunction

endpackage

// File: rtl/ctl_live_counter.sv
module ctl_live_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q == $past(cnt_q) + 1'b1)) else $error("counter step"); // R6
endmodule

// File: rtl/ctl_index_decode.sv
module ctl_index_decode
    import ctl_regfile_pkg::*;
(
    input  req_t    req,
    input  logic    once_set,
    output policy_t pol,
    output logic    err
);
    logic bad_dir;

    always_comb begin
        pol = policy_of(req.idx);
        if (req.write)
            bad_dir = !pol.wr_ok || (pol.kind == WK_ONCE && once_set);
        else
            bad_dir = !pol.rd_ok;
        err = req.valid && (!pol.known || bad_dir);
    end
endmodule

// File: rtl/ctl_reg_store.sv
module ctl_reg_store
    import ctl_regfile_pkg::*;
#(
    parameter int              CPU_ID_W   = 8,
    parameter logic [XLEN-1:0] RESET_BASE = 64'h0000_0000_0001_0000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CPU_ID_W-1:0] cpu_id,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  wr_kind_e            wr_kind,
    input  logic [XLEN-1:0]     wr_mask,
    input  logic [XLEN-1:0]     wr_data,
    input  logic [XLEN-1:0]     exc_set,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [XLEN-1:0]     rd_val,
    output logic                once_set,
    output logic [4:0]          irq_lvl
);
    logic [XLEN-1:0] regs [NUM_SLOTS];
    logic [XLEN-1:0] new_val;
    logic [XLEN-1:0] exc_next;

    always_comb begin
        new_val  = apply_write(wr_kind, wr_mask, wr_data);
        exc_next = ((wr_en && wr_idx == IX_EXC_SUM) ? '0 : regs[IX_EXC_SUM]) | exc_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) regs[i] <= '0;
            regs[IX_HW_CTRL]  <= HW_CTRL_INIT;
            regs[IX_ROM_BASE] <= RESET_BASE;
            regs[IX_SCR16]    <= XLEN'(cpu_id);
        end else begin
            if (wr_en) regs[wr_idx] <= new_val;
            regs[IX_EXC_SUM] <= exc_next;
        end
    end

    assign rd_val   = (rd_idx < IDX_W'(NUM_SLOTS)) ? regs[rd_idx] : '0;
    assign once_set = regs[IX_CYC_CTL][0];
    assign irq_lvl  = regs[IX_IRQ_LVL][4:0];

    AST_ONCE_STICKY: assert property (@(posedge clk) disable iff (rst)
        once_set |=> once_set) else $error("once flag dropped"); // R7
    AST_EXC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IX_EXC_SUM) |=> (regs[IX_EXC_SUM] == $past(exc_set)))
        else $error("summary not cleared"); // R5
endmodule

// File: rtl/ctl_event_out.sv
module ctl_event_out
    import ctl_regfile_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_acc,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       mode_bits,
    output logic             mode_user,
    output logic             mode_chg,
    output logic             dflush_stb,
    output logic             iflush_stb
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_user  <= 1'b0;
            mode_chg   <= 1'b0;
            dflush_stb <= 1'b0;
            iflush_stb <= 1'b0;
        end else begin
            mode_chg   <= wr_acc && wr_idx == IX_DATA_MODE;
            dflush_stb <= wr_acc && wr_idx == IX_DFLUSH;
            iflush_stb <= wr_acc && wr_idx == IX_IFLUSH;
            if (wr_acc && wr_idx == IX_DATA_MODE) mode_user <= |mode_bits;
        end
    end

    AST_DFLUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
        dflush_stb |-> $past(wr_acc && wr_idx == IX_DFLUSH)) else $error("stray flush"); // R12
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mode_chg |-> $stable(mode_user)) else $error("mode moved"); // R10
endmodule

// File: rtl/priv_ctl_regfile.sv
module priv_ctl_regfile
    import ctl_regfile_pkg::*;
#(
    parameter int              CPU_ID_W   = 8,
    parameter logic [XLEN-1:0] RESET_BASE = 64'h0000_0000_0001_0000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CPU_ID_W-1:0] cpu_id,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [IDX_W-1:0]    req_idx,
    input  logic [XLEN-1:0]     req_wdata,
    input  logic [XLEN-1:0]     exc_sum_set,
    output logic [XLEN-1:0]     rd_data,
    output logic                acc_err,
    output logic [4:0]          irq_level,
    output logic                mode_user,
    output logic                mode_chg,
    output logic                dflush_stb,
    output logic                iflush_stb
);
    req_t            req;
    policy_t         pol;
    logic            once_set;
    logic            wr_acc;
    logic [XLEN-1:0] slot_val;
    logic [CNT_W-1:0] live_cnt;
    logic [XLEN-1:0] merged;

    assign req = '{valid: req_valid, write: req_write, idx: req_idx, data: req_wdata};

    ctl_index_decode u_dec (
        .req      (req),
        .once_set (once_set),
        .pol      (pol),
        .err      (acc_err)
    );

    assign wr_acc = req.valid && req.write && !acc_err;

    ctl_reg_store #(.CPU_ID_W(CPU_ID_W), .RESET_BASE(RESET_BASE)) u_store (
        .clk      (clk),
        .rst      (rst),
        .cpu_id   (cpu_id),
        .wr_en    (wr_acc),
        .wr_idx   (req.idx),
        .wr_kind  (pol.kind),
        .wr_mask  (pol.mask),
        .wr_data  (req.data),
        .exc_set  (exc_sum_set),
        .rd_idx   (req.idx),
        .rd_val   (slot_val),
        .once_set (once_set),
        .irq_lvl  (irq_level)
    );

    ctl_live_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .count (live_cnt)
    );

    ctl_event_out u_evt (
        .clk        (clk),
        .rst        (rst),
        .wr_acc     (wr_acc),
        .wr_idx     (req.idx),
        .mode_bits  (req.data[4:3]),
        .mode_user  (mode_user),
        .mode_chg   (mode_chg),
        .dflush_stb (dflush_stb),
        .iflush_stb (iflush_stb)
    );

    always_comb begin
        merged = slot_val;
        if (req.idx == IX_CYC_CNT) merged = {slot_val[XLEN-1:CNT_W], live_cnt};
        rd_data = (req.valid && !req.write && !acc_err) ? merged : '0;
    end

    AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> (rd_data == '0)) else $error("data on error"); // R8
    AST_UNKNOWN_ERR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_idx >= IDX_W'(NUM_SLOTS)) |-> acc_err) else $error("unassigned ok"); // R9
endmodule

// File: tb/sim_priv_ctl_regfile.sv
module sim_priv_ctl_regfile;
    localparam logic [63:0] RBASE = 64'h0000_0000_0001_0000;
    localparam logic [7:0]  CPUID = 8'h5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_idx = '0;
    logic [63:0] req_wdata = '0, exc_sum_set = '0;
    logic [63:0] rd_data;
    logic        acc_err, mode_user, mode_chg, dflush_stb, iflush_stb;
    logic [4:0]  irq_level;

    int checks = 0, errors = 0;
    bit done = 0;
    string cur_tag = "R1";

    logic [63:0] m [47];
    logic [31:0] mcnt;
    logic        m_user, m_chg, m_df, m_if;

    always #4 clk = ~clk;

    priv_ctl_regfile #(.CPU_ID_W(8), .RESET_BASE(RBASE)) u0 (
        .clk(clk), .rst(rst), .cpu_id(CPUID),
        .req_valid(req_valid), .req_write(req_write), .req_idx(req_idx),
        .req_wdata(req_wdata), .exc_sum_set(exc_sum_set),
        .rd_data(rd_data), .acc_err(acc_err), .irq_level(irq_level),
        .mode_user(mode_user), .mode_chg(mode_chg),
        .dflush_stb(dflush_stb), .iflush_stb(iflush_stb)
    );

    function automatic logic [63:0] mask_of(input int i);
        case (i)
            26:         return ~64'h2;
            27, 28:     return 64'hF;
            29:         return 64'h1F;
            30, 31, 32: return 64'h18;
            33:         return 64'h7FFF0;
            34:         return 64'hFF_FFFF_0300;
            35:         return 64'hFFFF_FFFF_C000_0000;
            36, 37:     return 64'h3F;
            default:    return '1;
        endcase
    endfunction

    function automatic bit exp_err(input bit v, input bit w, input int i);
        if (!v) return 0;
        if (i >= 47) return 1;
        if (w) return (i == 42 || i == 43 || (i == 41 && m[41] != 0));
        return (i == 32 || i == 41 || i == 44 || i == 45 || i == 46);
    endfunction

    task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 47; i++) m[i] = '0;
            m[25] = 64'h6; m[24] = RBASE; m[16] = 64'(CPUID);
            mcnt = '0; m_user = 0; m_chg = 0; m_df = 0; m_if = 0;
        end else begin
            automatic bit e = exp_err(req_valid, req_write, int'(req_idx));
            mcnt++; m_chg = 0; m_df = 0; m_if = 0;
            if (req_valid && req_write && !e) begin
                automatic int i = int'(req_idx);
                if (i == 38 || i == 39) m[i] = '0;
                else if (i == 41) m[i] = 64'd1;
                else m[i] = req_wdata & mask_of(i);
                if (i == 31) begin m_user = |req_wdata[4:3]; m_chg = 1; end
                if (i == 45) m_df = 1;
                if (i == 46) m_if = 1;
            end
            m[38] = m[38] | exc_sum_set;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            automatic bit e = exp_err(req_valid, req_write, int'(req_idx));
            automatic logic [63:0] ev = '0;
            if (req_valid && !req_write && !e)
                ev = (req_idx == 6'd40) ? {m[40][63:32], mcnt} : m[req_idx];
            cmp(cur_tag, "acc_err", 64'(acc_err), 64'(e));
            cmp(e ? "R8" : (req_valid && !req_write) ? cur_tag : "R13", "rd_data", rd_data, ev);
            cmp("R11", "irq_level", 64'(irq_level), 64'(m[29][4:0]));
            cmp("R10", "mode_user", 64'(mode_user), 64'(m_user));
            cmp("R10", "mode_chg", 64'(mode_chg), 64'(m_chg));
            cmp("R12", "dflush_stb", 64'(dflush_stb), 64'(m_df));
            cmp("R12", "iflush_stb", 64'(iflush_stb), 64'(m_if));
        end
    end

    task automatic acc(input bit v, input bit w, input int i, input logic [63:0] d);
        @(negedge clk); #1;
        req_valid = v; req_write = w; req_idx = 6'(i); req_wdata = d;
    endtask

    task automatic wr_rd(input int i, input logic [63:0] d);
        acc(1, 1, i, d);
        acc(1, 0, i, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R13 watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst = 0;
        cur_tag = "R1";
        foreach (m[i]) if (i != 32 && i != 41 && (i < 44)) acc(1, 0, i, '0);
        cur_tag = "R2";
        wr_rd(3, 64'hDEAD_BEEF_0123_4567);
        wr_rd(23, 64'h8000_0000_0000_0001);
        wr_rd(24, 64'hFEDC_BA98_7654_3210);
        wr_rd(25, 64'h0F0F_0F0F_F0F0_F0F0);
        acc(1, 1, 44, 64'h1234_5678_9ABC_DEF0);
        cur_tag = "R3";
        for (int i = 27; i <= 37; i++) begin
            wr_rd(i, '1);
            wr_rd(i, 64'hA5A5_A5A5_A5A5_A5A5);
        end
        cur_tag = "R4";
        wr_rd(26, '1);
        wr_rd(26, 64'h0000_0000_0000_0006);
        cur_tag = "R5";
        @(negedge clk); #1 exc_sum_set = 64'h0F01; req_valid = 0;
        @(negedge clk); #1 exc_sum_set = '0;
        acc(1, 0, 38, '0);
        acc(1, 1, 38, '1);
        acc(1, 0, 38, '0);
        acc(1, 1, 38, '0); exc_sum_set = 64'h30;
        @(negedge clk); #1 exc_sum_set = '0; req_valid = 1; req_write = 0;
        wr_rd(39, '1);
        cur_tag = "R6";
        wr_rd(40, 64'hCAFE_F00D_1111_2222);
        repeat (5) acc(0, 0, 0, '0);
        acc(1, 0, 40, '0);
        repeat (9) acc(1, 0, 40, '0);
        cur_tag = "R7";
        acc(1, 1, 41, 64'h55);
        acc(1, 1, 41, 64'h55);
        acc(1, 0, 41, '0);
        cur_tag = "R8";
        acc(1, 1, 42, '1);
        acc(1, 0, 42, '0);
        acc(1, 1, 43, '1);
        acc(1, 0, 43, '0);
        acc(1, 0, 44, '0);
        acc(1, 0, 45, '0);
        acc(1, 0, 32, '0);
        cur_tag = "R9";
        acc(1, 0, 47, '0);
        acc(1, 1, 50, '1);
        acc(1, 1, 63, '1);
        acc(1, 0, 63, '0);
        cur_tag = "R10";
        wr_rd(31, 64'h08);
        wr_rd(31, 64'h00);
        wr_rd(31, 64'h10);
        wr_rd(30, 64'h00);
        wr_rd(31, 64'hFFFF_FFFF_FFFF_FFE7);
        cur_tag = "R11";
        wr_rd(29, 64'hFF);
        wr_rd(29, 64'h0A);
        cur_tag = "R12";
        acc(1, 1, 45, 64'h1);
        acc(1, 1, 46, 64'h1);
        acc(1, 1, 45, 64'h1);
        acc(1, 1, 45, 64'h1);
        acc(0, 1, 46, 64'h1);
        cur_tag = "R13";
        acc(0, 0, 3, '0);
        acc(0, 1, 3, '1);
        acc(1, 0, 3, '0);
        repeat (3) acc(0, 0, 0, '0);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule